// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer for 9-bit words whose producer and consumer may sit on separate clocks or share one. A word is stored on a write-clock edge when both write enables are high, and the oldest word moves into the read data register on a read-clock edge when both read enables are high. The read data bus floats while the output enable is low. Each pointer crosses into the other domain as Gray code through a two-flop synchronizer. Empty and Almost-Empty are computed in the read domain, and Full and Almost-Full in the write domain.

The Almost-Empty and Almost-Full thresholds are set by two offset registers, and both offsets are 7 after reset. While the load input is high, each qualified write cycle loads one byte of the offsets from `wr_data[7:0]` and does not touch the memory. The bytes load in a fixed rotating order: empty-offset low, empty-offset high, full-offset low, full-offset high, and then back to the first. The offsets are meant to be loaded while the buffer is idle, because the read side samples the empty offset without synchronizing it.

Top module: `dcfifo_pflag`

## Requirements
- R1: On a rising `wr_clk` edge with `wr_en_a`, `wr_en_b` high, `load` low and `full` low, `wr_data` is stored. Stored words leave through the read port in the order they were written.
- R2: A read happens only on a rising `rd_clk` edge with both `rd_en_a` and `rd_en_b` high. With only one of them high, `rd_data` and the buffer contents are unchanged.
- R3: A write attempted while `full` is high is dropped. No extra word appears on later reads.
- R4: A read attempted while `empty` is high leaves `rd_data` holding its previous value and moves no pointer.
- R5: While `rst_n` is low, the pointers and the read data register clear and both offsets return to 7. After reset, `empty`=1, `almost_empty`=1, `full`=0 and `almost_full`=0.
- R6: `full` is high exactly when the write-domain count equals DEPTH. `almost_full` is high when that count is at least DEPTH minus the full offset, so with default offsets it rises at DEPTH-7 words.
- R7: After the first write into an empty buffer, `empty` stays high through the next rising read-clock edge and falls at the second one (same clock). `almost_empty` is high while the read-domain count is at most the empty offset, so it is 1 at 7 words and 0 at 8 with defaults.
- R8: Offset byte order while `load` is high: empty-offset bits [7:0], empty-offset bits [15:8], full-offset bits [7:0], full-offset bits [15:8], each taken from `wr_data[7:0]`. Only offset bits below log2(DEPTH) take part in the flag comparisons.
- R9: Offset-load cycles write nothing into the buffer. The fifth load cycle writes the empty-offset low byte again.
- R10: While `out_en` is low, `rd_data` is high impedance.
- R11: A read moves the head word into `rd_data` by the end of its read-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_en_a | input | 1 | First write enable, active high |
| wr_en_b | input | 1 | Second write enable, active high |
| load | input | 1 | Steers qualified writes into the offset registers |
| wr_data | input | 9 | Write data; bits [7:0] also carry offset bytes |
| rd_en_a | input | 1 | First read enable, active high |
| rd_en_b | input | 1 | Second read enable, active high |
| out_en | input | 1 | Drives `rd_data` when high, floats it when low |
| rd_data | output | 9 | Registered read data |
| empty | output | 1 | No words visible to the read side |
| almost_empty | output | 1 | Read-side count at or below the empty offset |
| full | output | 1 | DEPTH words visible to the write side |
| almost_full | output | 1 | Write-side count at or above DEPTH minus the full offset |

## Verification
The data path is first exercised with a single write, then a full 512-word burst, and then partial fills. Each word is a distinct value, so a dropped, duplicated or reordered word appears as a scoreboard mismatch. Enable pairs are also driven with only one side high, which separates a gate that needs both enables from one that needs either. The flag thresholds are probed one word on each side of the edge, first with the default offsets and then after an offset load. That load puts junk in the empty-offset high byte and a set bit 8 in the full-offset high byte, which separates correct byte order and width masking from wrong ones. A fifth load cycle shows whether the byte sequence wraps.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    localparam int OFS_W = 16;
    localparam logic [OFS_W-1:0] OFS_RESET = 16'd7;

    typedef enum logic [1:0] {
        LD_E_LO = 2'd0,
        LD_E_HI = 2'd1,
        LD_F_LO = 2'd2,
        LD_F_HI = 2'd3
    } ld_step_e;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q, sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
    import dcf_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic             load_i,
    input  logic [7:0]       byte_i,
    input  logic [AW:0]      rgray_sync_i,
    output logic [AW-1:0]    waddr_o,
    output logic [AW:0]      wgray_o,
    output logic             mem_we_o,
    output logic             full_o,
    output logic             almost_full_o,
    output logic [OFS_W-1:0] ofs_e_o
);
    localparam logic [AW:0]      DEPTH_C  = (AW+1)'(DEPTH);
    localparam logic [OFS_W-1:0] DEPTH_16 = OFS_W'(DEPTH);
    localparam logic [OFS_W-1:0] OFS_MASK = OFS_W'((1 << AW) - 1);

    typedef struct packed {
        logic [AW:0]      bin;
        logic [AW:0]      gray;
        ld_step_e         step;
        logic [OFS_W-1:0] ofs_e;
        logic [OFS_W-1:0] ofs_f;
    } wst_t;

    wst_t        st_d, st_q;
    logic [AW:0] rbin;
    logic [AW:0] cnt;
    logic [AW:0] bin_inc;

    always_comb begin
        rbin[AW] = rgray_sync_i[AW];
        for (int i = AW - 1; i >= 0; i--) begin
            rbin[i] = rbin[i+1] ^ rgray_sync_i[i];
        end
        cnt           = st_q.bin - rbin;
        full_o        = (cnt == DEPTH_C);
        almost_full_o = (OFS_W'(cnt) + (st_q.ofs_f & OFS_MASK)) >= DEPTH_16;
        mem_we_o      = we_i && !load_i && !full_o;
        bin_inc       = st_q.bin + 1'b1;

        st_d = st_q;
        if (mem_we_o) begin
            st_d.bin  = bin_inc;
            st_d.gray = bin_inc ^ (bin_inc >> 1);
        end
        if (we_i && load_i) begin
            case (st_q.step)
                LD_E_LO: begin st_d.ofs_e[7:0]  = byte_i; st_d.step = LD_E_HI; end
                LD_E_HI: begin st_d.ofs_e[15:8] = byte_i; st_d.step = LD_F_LO; end
                LD_F_LO: begin st_d.ofs_f[7:0]  = byte_i; st_d.step = LD_F_HI; end
                default: begin st_d.ofs_f[15:8] = byte_i; st_d.step = LD_E_LO; end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bin   <= '0;
            st_q.gray  <= '0;
            st_q.step  <= LD_E_LO;
            st_q.ofs_e <= OFS_RESET;
            st_q.ofs_f <= OFS_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign waddr_o = st_q.bin[AW-1:0];
    assign wgray_o = st_q.gray;
    assign ofs_e_o = st_q.ofs_e;

    // R3: a write against a full buffer leaves the write pointer alone
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && we_i) |=> $stable(st_q.bin));
    // R9: offset-load cycles never advance the write pointer
    p_load_no_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> $stable(st_q.bin));
    // R6: occupancy seen by the writer never exceeds the depth
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= DEPTH_C);
    // R6: full implies almost full
    p_full_af_r6: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> almost_full_o);
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
    import dcf_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             re_i,
    input  logic [AW:0]      wgray_sync_i,
    input  logic [OFS_W-1:0] ofs_e_i,
    output logic [AW-1:0]    raddr_o,
    output logic [AW:0]      rgray_o,
    output logic             fire_o,
    output logic             empty_o,
    output logic             almost_empty_o
);
    localparam logic [OFS_W-1:0] OFS_MASK = OFS_W'((1 << AW) - 1);

    typedef struct packed {
        logic [AW:0] bin;
        logic [AW:0] gray;
    } rst_t;

    rst_t        st_d, st_q;
    logic [AW:0] wbin;
    logic [AW:0] cnt;
    logic [AW:0] bin_inc;

    always_comb begin
        wbin[AW] = wgray_sync_i[AW];
        for (int i = AW - 1; i >= 0; i--) begin
            wbin[i] = wbin[i+1] ^ wgray_sync_i[i];
        end
        cnt            = wbin - st_q.bin;
        empty_o        = (cnt == '0);
        almost_empty_o = OFS_W'(cnt) <= (ofs_e_i & OFS_MASK);
        fire_o         = re_i && !empty_o;
        bin_inc        = st_q.bin + 1'b1;

        st_d = st_q;
        if (fire_o) begin
            st_d.bin  = bin_inc;
            st_d.gray = bin_inc ^ (bin_inc >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr_o = st_q.bin[AW-1:0];
    assign rgray_o = st_q.gray;

    // R4: a read against an empty buffer leaves the read pointer alone
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && re_i) |=> $stable(st_q.bin));
    // R2: without a qualified read the read pointer holds
    p_rd_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !re_i |=> $stable(st_q.bin));
    // R7: empty implies almost empty
    p_empty_ae_r7: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> almost_empty_o);
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag
    import dcf_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int DW    = 9
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          wr_en_a,
    input  logic          wr_en_b,
    input  logic          load,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en_a,
    input  logic          rd_en_b,
    input  logic          out_en,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic          almost_empty,
    output logic          full,
    output logic          almost_full
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0]    mem [DEPTH];
    logic [AW-1:0]    waddr, raddr;
    logic [AW:0]      wgray, rgray, wgray_rs, rgray_ws;
    logic             mem_we, rd_fire;
    logic [OFS_W-1:0] ofs_e;
    logic [DW-1:0]    dout_d, dout_q;

    dcf_wr_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_wr (
        .clk          (wr_clk),
        .rst_n        (rst_n),
        .we_i         (wr_en_a & wr_en_b),
        .load_i       (load),
        .byte_i       (wr_data[7:0]),
        .rgray_sync_i (rgray_ws),
        .waddr_o      (waddr),
        .wgray_o      (wgray),
        .mem_we_o     (mem_we),
        .full_o       (full),
        .almost_full_o(almost_full),
        .ofs_e_o      (ofs_e)
    );

    dcf_rd_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_rd (
        .clk           (rd_clk),
        .rst_n         (rst_n),
        .re_i          (rd_en_a & rd_en_b),
        .wgray_sync_i  (wgray_rs),
        .ofs_e_i       (ofs_e),
        .raddr_o       (raddr),
        .rgray_o       (rgray),
        .fire_o        (rd_fire),
        .empty_o       (empty),
        .almost_empty_o(almost_empty)
    );

    dcf_sync #(.W(AW+1)) u_w2r (
        .clk  (rd_clk),
        .rst_n(rst_n),
        .d_i  (wgray),
        .q_o  (wgray_rs)
    );

    dcf_sync #(.W(AW+1)) u_r2w (
        .clk  (wr_clk),
        .rst_n(rst_n),
        .d_i  (rgray),
        .q_o  (rgray_ws)
    );

    always_ff @(posedge wr_clk) begin
        if (mem_we) begin
            mem[waddr] <= wr_data;
        end
    end

    always_comb begin
        dout_d = dout_q;
        if (rd_fire) begin
            dout_d = mem[raddr];
        end
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else begin
            dout_q <= dout_d;
        end
    end

    assign rd_data = out_en ? dout_q : 'z;

    // R4: the read data register only changes on a read while not empty
    p_rd_hold_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (empty || !(rd_en_a && rd_en_b)) |=> $stable(dout_q));
    // R5: full and empty are never high together
    p_flags_exclusive_r5: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !(full && empty));
endmodule

// File: tb/dcfifo_pflag_tb_top.sv
module dcfifo_pflag_tb_top;
    localparam int DEPTH = 512;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       wr_en_a = 0, wr_en_b = 0, load = 0;
    logic [8:0] wr_data = '0;
    logic       rd_en_a = 0, rd_en_b = 0, out_en = 1;
    wire  [8:0] rd_data;
    logic       empty, almost_empty, full, almost_full;

    dcfifo_pflag #(.DEPTH(DEPTH), .DW(9)) dut_i (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
        .wr_en_a(wr_en_a), .wr_en_b(wr_en_b), .load(load), .wr_data(wr_data),
        .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .out_en(out_en), .rd_data(rd_data),
        .empty(empty), .almost_empty(almost_empty), .full(full), .almost_full(almost_full)
    );

    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 0;
    logic [8:0] exp_q[$];
    logic       fire_req = 0;
    logic       mon_fire = 0;
    logic [8:0] last_rd = '0;
    int         seq = 0;

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares each completed read against the scoreboard queue
    always @(posedge clk) mon_fire <= fire_req;
    always @(negedge clk) begin
        logic [8:0] e;
        if (mon_fire) begin
            if (exp_q.size() == 0) begin
                chk(0, "R1 read with no expected word", {7'd0, rd_data}, 16'd0);
            end else begin
                e = exp_q.pop_front();
                chk(rd_data === e, "R1 R11 read order/data", {7'd0, rd_data}, {7'd0, e});
                last_rd = e;
            end
        end
    end

    task automatic wr(input logic [8:0] d, input logic a = 1'b1, input logic b = 1'b1);
        wr_data = d;
        wr_en_a = a;
        wr_en_b = b;
        if (a && b && !load && !full) exp_q.push_back(d);
        @(negedge clk);
        wr_en_a = 0;
        wr_en_b = 0;
    endtask

    task automatic rd(input logic a = 1'b1, input logic b = 1'b1);
        rd_en_a  = a;
        rd_en_b  = b;
        fire_req = a && b && !empty;
        @(negedge clk);
        rd_en_a  = 0;
        rd_en_b  = 0;
        fire_req = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [8:0] pat();
        seq++;
        return 9'((seq * 37 + 11) & 9'h1FF);
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired (R1 run hung) act=1 exp=0");
        summary();
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R5 reset state
        chk(empty == 1'b1,        "R5 empty after reset",        {15'd0, empty}, 16'd1);
        chk(almost_empty == 1'b1, "R5 almost_empty after reset", {15'd0, almost_empty}, 16'd1);
        chk(full == 1'b0,         "R5 full after reset",         {15'd0, full}, 16'd0);
        chk(almost_full == 1'b0,  "R5 almost_full after reset",  {15'd0, almost_full}, 16'd0);
        chk(rd_data === 9'd0,     "R5 rd_data after reset",      {7'd0, rd_data}, 16'd0);

        // R10 high impedance
        out_en = 0;
        #1;
        chk(rd_data === 9'bz_zzzz_zzzz, "R10 rd_data floats", {7'd0, rd_data}, 16'hFFFF);
        out_en = 1;
        idle(1);

        // R7 empty latency
        wr(9'h101);
        chk(empty == 1'b1, "R7 empty right after write", {15'd0, empty}, 16'd1);
        idle(1);
        chk(empty == 1'b1, "R7 empty after first read edge", {15'd0, empty}, 16'd1);
        idle(1);
        chk(empty == 1'b0, "R7 empty falls at second edge", {15'd0, empty}, 16'd0);

        // R2 single read enable has no effect
        rd(1'b1, 1'b0);
        chk(rd_data === 9'd0, "R2 rd_en_a alone", {7'd0, rd_data}, 16'd0);
        rd(1'b0, 1'b1);
        chk(rd_data === 9'd0, "R2 rd_en_b alone", {7'd0, rd_data}, 16'd0);
        chk(empty == 1'b0, "R2 word still held", {15'd0, empty}, 16'd0);
        rd();
        idle(1);
        chk(empty == 1'b1, "R11 buffer empty after single read", {15'd0, empty}, 16'd1);

        // R4 read while empty
        rd();
        chk(rd_data === 9'h101, "R4 rd_data holds on empty read", {7'd0, rd_data}, 16'h101);

        // R1 single write enable ignored
        wr(9'h055, 1'b1, 1'b0);
        wr(9'h066, 1'b0, 1'b1);
        idle(3);
        chk(empty == 1'b1, "R1 one write enable stores nothing", {15'd0, empty}, 16'd1);

        // R7 default empty offset: 7 words almost empty, 8 not
        for (int i = 0; i < 7; i++) wr(pat());
        idle(3);
        chk(almost_empty == 1'b1, "R7 almost_empty at 7 words", {15'd0, almost_empty}, 16'd1);
        wr(pat());
        idle(3);
        chk(almost_empty == 1'b0, "R7 almost_empty at 8 words", {15'd0, almost_empty}, 16'd0);

        // R6 default full offset and full
        for (int i = 8; i < DEPTH - 8; i++) wr(pat());
        chk(almost_full == 1'b0, "R6 almost_full at DEPTH-8", {15'd0, almost_full}, 16'd0);
        wr(pat());
        chk(almost_full == 1'b1, "R6 almost_full at DEPTH-7", {15'd0, almost_full}, 16'd1);
        for (int i = DEPTH - 7; i < DEPTH - 1; i++) wr(pat());
        chk(full == 1'b0, "R6 not full at DEPTH-1", {15'd0, full}, 16'd0);
        wr(pat());
        chk(full == 1'b1, "R6 full at DEPTH", {15'd0, full}, 16'd1);

        // R3 write while full dropped
        wr(9'h1AA);
        chk(full == 1'b1, "R3 still full after dropped write", {15'd0, full}, 16'd1);
        for (int i = 0; i < DEPTH; i++) rd();
        idle(2);
        chk(empty == 1'b1, "R3 empty after draining DEPTH words", {15'd0, empty}, 16'd1);
        chk(exp_q.size() == 0, "R3 scoreboard drained", 16'(exp_q.size()), 16'd0);
        rd();
        chk(rd_data === last_rd, "R3 no extra word stored", {7'd0, rd_data}, {7'd0, last_rd});

        // R8 R9 offset load: empty=20 (junk above bit 8), full=300 (bit 8 set)
        load = 1;
        wr(9'h014);
        wr(9'h0FE);
        wr(9'h02C);
        wr(9'h001);
        load = 0;
        idle(3);
        chk(empty == 1'b1, "R9 load cycles store nothing", {15'd0, empty}, 16'd1);
        chk(full == 1'b0, "R9 load cycles not counted", {15'd0, full}, 16'd0);
        for (int i = 0; i < 20; i++) wr(pat());
        idle(3);
        chk(almost_empty == 1'b1, "R8 almost_empty at 20 words", {15'd0, almost_empty}, 16'd1);
        wr(pat());
        idle(3);
        chk(almost_empty == 1'b0, "R8 almost_empty at 21 words", {15'd0, almost_empty}, 16'd0);
        for (int i = 21; i < 211; i++) wr(pat());
        chk(almost_full == 1'b0, "R8 almost_full at 211 words", {15'd0, almost_full}, 16'd0);
        wr(pat());
        chk(almost_full == 1'b1, "R8 almost_full at 212 words", {15'd0, almost_full}, 16'd1);
        for (int i = 0; i < 212; i++) rd();
        idle(2);
        chk(empty == 1'b1, "R8 empty after drain", {15'd0, empty}, 16'd1);

        // R9 sequence wraps: fifth byte is empty-offset low again
        load = 1;
        wr(9'h001);
        wr(9'h000);
        wr(9'h000);
        wr(9'h000);
        wr(9'h003);
        load = 0;
        idle(3);
        chk(empty == 1'b1, "R9 wrap load stores nothing", {15'd0, empty}, 16'd1);
        for (int i = 0; i < 3; i++) wr(pat());
        idle(3);
        chk(almost_empty == 1'b1, "R9 almost_empty at 3 after wrap", {15'd0, almost_empty}, 16'd1);
        wr(pat());
        idle(3);
        chk(almost_empty == 1'b0, "R9 almost_empty at 4 after wrap", {15'd0, almost_empty}, 16'd0);
        chk(almost_full == 1'b0, "R6 zero full offset gives no early flag", {15'd0, almost_full}, 16'd0);
        for (int i = 0; i < 4; i++) rd();
        idle(2);
        chk(exp_q.size() == 0, "R1 scoreboard empty at end", 16'(exp_q.size()), 16'd0);

        summary();
        $finish;
    end
endmodule